// File: doc/BRIEF.md
# Board Interrupt Aggregator

This block gathers level interrupt requests from eight board sources into an 8-bit status register. It combines status with an enable register to form a cause register, then routes the cause bits through three programmable map registers onto three active-high CPU interrupt lines. Each line is chosen by its own mask, and any cause bit may appear on several lines at once.

A small word-addressed register bus reads and writes the enable, map and board control registers, and reads the status and cause registers. Two serial channels share one status bit. Software can drop a pending vertical-blank status by moving bit 0 of the board control register from 1 to 0, even while the vertical-blank request is still high.

Each CPU line is driven by a two-state machine. The state LINE_IDLE holds the line low and LINE_RAISED holds it high. The ASSERT transition goes from LINE_IDLE to LINE_RAISED when the line's masked cause becomes nonzero. The RELEASE transition goes from LINE_RAISED to LINE_IDLE when that masked cause becomes zero. Outside those two transitions the line does not change.

Top module: `board_irq_hub`

## Requirements
- R1: Status bit i follows source request `src_req[i]`. The bit order is fixed: 0 I/O controller, 1 ROM bus, 2 graphics, 3 serial pair, 4 PCI slot/USB, 5 watchdog, 6 A/D converter, 7 vertical blank.
- R2: Status bit 3 is driven by the OR of `src_req[3]`, `uart_req[0]` and `uart_req[1]`. It stays set while any of them requests and clears when all three are low.
- R3: A status bit is set at the first clock edge at which its request is seen high after being low. It is cleared at the first edge at which the request is seen low after being high. Otherwise it holds its value.
- R4: Cause equals enable AND status. It is readable at word address 2, and writes to address 2 are ignored.
- R5: `cpu_irq[k]` is high exactly when cause AND map[k] is nonzero. It is updated at the same clock edge that changes status, enable or map[k].
- R6: A write to the enable register (address 1) takes effect at the write edge. Clearing an enable bit drops any line whose only mapped cause came from that bit.
- R7: The board control register is at address 6, and only bit 0 is stored. Writing bit 0 as 0 while the stored bit 0 is 1 clears status bit 7. Writing 0 when the stored bit is already 0 has no effect. A vertical-blank rising edge at the same clock edge wins over the clear.
- R8: Each line's machine takes the ASSERT transition only when its masked cause is nonzero, and the RELEASE transition only when it is zero. The line changes level only on these transitions.
- R9: After reset, status, enable, cause, all maps and the control register read zero, and `cpu_irq` is 0.
- R10: The bus map is: 0 status (read-only, writes ignored), 1 enable, 2 cause, 3..5 map0..map2, 6 board control, 7 reads zero. `bus_rdata` is valid on the clock after the edge that samples `bus_rd` and holds until the next read. Bits 31:8 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 8 | Synchronous level requests, one per status bit |
| uart_req | input | 2 | Serial channel requests sharing status bit 3 |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 3 | Active-high CPU interrupt lines |

## Verification
On every cycle the assertions check four things:
- each status bit sets on a request rise and clears on a fall;
- a vertical-blank clear without a competing rise leaves bit 7 low;
- every CPU line equals the OR of its masked cause;
- the line machines move only when their masked cause allows it.

Only the bench scenarios can show the rest:
- the exact bit positions and the sharing of bit 3;
- the cycle at which an enable write reaches a line;
- that writes to status and cause leave them unchanged;
- the distinction between a 1-to-0 and a 0-to-0 control write, and the rise-wins ordering.

The bench sweeps all 256 request patterns under four enable values, so every line sees every cause combination.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;
    localparam int NSRC       = 8;
    localparam int NLINE      = 3;
    localparam int DW         = 32;
    localparam int AW         = 3;
    localparam int NUART      = 2;
    localparam int SHARED_BIT = 3;
    localparam int VB_BIT     = 7;
    localparam int MAP_BASE   = 3;

    typedef enum logic [2:0] {
        A_STATUS = 3'd0,
        A_ENABLE = 3'd1,
        A_CAUSE  = 3'd2,
        A_MAP0   = 3'd3,
        A_MAP1   = 3'd4,
        A_MAP2   = 3'd5,
        A_BCTRL  = 3'd6,
        A_SPARE  = 3'd7
    } reg_addr_e;

    typedef enum logic {
        LINE_IDLE,
        LINE_RAISED
    } line_state_e;
endpackage

// File: rtl/board_irq_status.sv
module board_irq_status #(
    parameter int NSRC       = 8,
    parameter int NUART      = 2,
    parameter int SHARED_BIT = 3,
    parameter int VB_BIT     = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic [NUART-1:0] uart_req,
    input  logic            vb_clr,
    output logic [NSRC-1:0] stat_next,
    output logic [NSRC-1:0] stat_q
);
    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] lvl_q;

    always_comb begin
        lvl = src_req;
        lvl[SHARED_BIT] = src_req[SHARED_BIT] | (|uart_req);
    end

    always_comb begin
        stat_next = stat_q;
        for (int i = 0; i < NSRC; i++) begin
            if (lvl[i] && !lvl_q[i])
                stat_next[i] = 1'b1;
            else if (!lvl[i] && lvl_q[i])
                stat_next[i] = 1'b0;
            else if ((i == VB_BIT) && vb_clr)
                stat_next[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            stat_q <= '0;
        end else begin
            lvl_q  <= lvl;
            stat_q <= stat_next;
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        // R3
        rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lvl[g]) |=> stat_q[g]);
        // R3
        fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lvl[g]) |=> !stat_q[g]);
    end

    // R7
    vb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_clr && !lvl[VB_BIT]) |=> !stat_q[VB_BIT]);
endmodule

// File: rtl/board_irq_regs.sv
module board_irq_regs
    import board_irq_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int NLINE = 3,
    parameter int DW    = 32,
    parameter int AW    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic                        rd,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    input  logic [NSRC-1:0]             stat_q,
    output logic [NSRC-1:0]             en_q,
    output logic [NSRC-1:0]             en_next,
    output logic [NLINE-1:0][NSRC-1:0]  map_q,
    output logic [NLINE-1:0][NSRC-1:0]  map_next,
    output logic                        vb_clr,
    output logic [DW-1:0]               rdata
);
    logic          bctl_q;
    logic [DW-1:0] rd_mux;
    logic          unused_wdata;

    assign unused_wdata = &{1'b0, wdata[DW-1:NSRC]};
    assign vb_clr = wr && (reg_addr_e'(addr) == A_BCTRL) && !wdata[0] && bctl_q;

    always_comb begin
        en_next  = en_q;
        map_next = map_q;
        if (wr && (reg_addr_e'(addr) == A_ENABLE))
            en_next = wdata[NSRC-1:0];
        for (int k = 0; k < NLINE; k++) begin
            if (wr && (addr == AW'(MAP_BASE + k)))
                map_next[k] = wdata[NSRC-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (reg_addr_e'(addr))
            A_STATUS: rd_mux[NSRC-1:0] = stat_q;
            A_ENABLE: rd_mux[NSRC-1:0] = en_q;
            A_CAUSE:  rd_mux[NSRC-1:0] = en_q & stat_q;
            A_BCTRL:  rd_mux[0]        = bctl_q;
            default:  rd_mux           = '0;
        endcase
        for (int k = 0; k < NLINE; k++) begin
            if (addr == AW'(MAP_BASE + k))
                rd_mux[NSRC-1:0] = map_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            map_q  <= '0;
            bctl_q <= 1'b0;
            rdata  <= '0;
        end else begin
            en_q  <= en_next;
            map_q <= map_next;
            if (wr && (reg_addr_e'(addr) == A_BCTRL))
                bctl_q <= wdata[0];
            if (rd)
                rdata <= rd_mux;
        end
    end

    // R6
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (reg_addr_e'(addr) == A_ENABLE)) |=> (en_q == $past(wdata[NSRC-1:0])));
    // R10
    rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (rdata[DW-1:NSRC] == '0));
endmodule

// File: rtl/board_irq_line.sv
module board_irq_line
    import board_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic irq
);
    line_state_e state_q;
    line_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LINE_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        irq     = 1'b0;
        unique case (state_q)
            LINE_IDLE: begin
                if (hit)
                    state_d = LINE_RAISED;
            end
            LINE_RAISED: begin
                irq = 1'b1;
                if (!hit)
                    state_d = LINE_IDLE;
            end
        endcase
    end

    // R8
    line_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit));
    // R8
    line_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> !$past(hit));
endmodule

// File: rtl/board_irq_hub.sv
module board_irq_hub
    import board_irq_pkg::*;
#(
    parameter int P_NSRC  = NSRC,
    parameter int P_NLINE = NLINE,
    parameter int P_DW    = DW,
    parameter int P_AW    = AW,
    parameter int P_NUART = NUART
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [P_NSRC-1:0]  src_req,
    input  logic [P_NUART-1:0] uart_req,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [P_AW-1:0]    bus_addr,
    input  logic [P_DW-1:0]    bus_wdata,
    output logic [P_DW-1:0]    bus_rdata,
    output logic [P_NLINE-1:0] cpu_irq
);
    logic [P_NSRC-1:0]               stat_next;
    logic [P_NSRC-1:0]               stat_q;
    logic [P_NSRC-1:0]               en_q;
    logic [P_NSRC-1:0]               en_next;
    logic [P_NLINE-1:0][P_NSRC-1:0]  map_q;
    logic [P_NLINE-1:0][P_NSRC-1:0]  map_next;
    logic                            vb_clr;
    logic [P_NSRC-1:0]               cause_next;

    board_irq_status #(
        .NSRC(P_NSRC), .NUART(P_NUART), .SHARED_BIT(SHARED_BIT), .VB_BIT(VB_BIT)
    ) status_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .uart_req(uart_req),
        .vb_clr(vb_clr), .stat_next(stat_next), .stat_q(stat_q)
    );

    board_irq_regs #(
        .NSRC(P_NSRC), .NLINE(P_NLINE), .DW(P_DW), .AW(P_AW)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .stat_q(stat_q), .en_q(en_q), .en_next(en_next),
        .map_q(map_q), .map_next(map_next), .vb_clr(vb_clr), .rdata(bus_rdata)
    );

    assign cause_next = stat_next & en_next;

    for (genvar k = 0; k < P_NLINE; k++) begin : g_line
        board_irq_line line_i (
            .clk(clk), .rst_n(rst_n),
            .hit(|(cause_next & map_next[k])),
            .irq(cpu_irq[k])
        );

        // R5
        irq_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[k] == (|(stat_q & en_q & map_q[k])));
    end
endmodule

// File: tb/board_irq_hub_tb.sv
`timescale 1ns/1ps
module board_irq_hub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_req = '0;
    logic [1:0]  uart_req = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  cpu_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    board_irq_hub dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .uart_req(uart_req),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    function automatic logic [2:0] exp_irq(input logic [7:0] st, input logic [7:0] en,
                                           input logic [7:0] m0, input logic [7:0] m1,
                                           input logic [7:0] m2);
        logic [7:0] c;
        c = st & en;
        return {|(c & m2), |(c & m1), |(c & m0)};
    endfunction

    initial begin
        logic [31:0] v;
        logic [7:0]  enl [4];
        logic [7:0]  m0, m1, m2, en, prev;
        logic [2:0]  old_irq;
        enl[0] = 8'hFF; enl[1] = 8'hA5; enl[2] = 8'h3C; enl[3] = 8'h00;
        m0 = 8'h0F; m1 = 8'hF0; m2 = 8'h88;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 irq after reset", {29'd0, cpu_irq}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            bus_read(3'(a), v);
            check("R9 reg after reset", v, 32'd0);
        end

        bus_write(3'd3, {24'd0, m0});
        bus_write(3'd4, {24'd0, m1});
        bus_write(3'd5, {24'd0, m2});
        prev = 8'h00;
        en = 8'h00;

        // R1 R3 R4 R5 R6: full sweep of request patterns under several enables
        for (int e = 0; e < 4; e++) begin
            bus_write(3'd1, {24'd0, enl[e]});
            en = enl[e];
            check("R6 enable write reaches lines at write edge", {29'd0, cpu_irq},
                  {29'd0, exp_irq(prev, en, m0, m1, m2)});
            for (int p = 0; p < 256; p++) begin
                @(negedge clk);
                old_irq = cpu_irq;
                src_req = 8'(p);
                #1;
                check("R3 no change before edge", {29'd0, cpu_irq}, {29'd0, old_irq});
                @(negedge clk);
                check("R5 line levels", {29'd0, cpu_irq},
                      {29'd0, exp_irq(8'(p), en, m0, m1, m2)});
                if ((p % 17) == 0 || p == 255) begin
                    bus_read(3'd0, v);
                    check("R1 status follows requests", v, 32'(p));
                    bus_read(3'd2, v);
                    check("R4 cause is enable and status", v, 32'(8'(p) & en));
                end
                prev = 8'(p);
            end
        end

        // R2: shared serial bit
        bus_write(3'd1, 32'hFF);
        en = 8'hFF;
        for (int b = 0; b < 2; b++) begin
            for (int u = 0; u < 4; u++) begin
                @(negedge clk);
                src_req = {4'd0, 1'(b), 3'd0};
                uart_req = 2'(u);
                @(negedge clk);
                bus_read(3'd0, v);
                check("R2 shared bit 3", v, {28'd0, (b != 0) || (u != 0), 3'd0});
                check("R2 shared bit on line 0", {31'd0, cpu_irq[0]},
                      {31'd0, (b != 0) || (u != 0)});
            end
        end
        @(negedge clk);
        src_req = '0; uart_req = '0;

        // R7: vertical-blank clear from the board control register
        @(negedge clk);
        src_req = 8'h80;
        @(negedge clk);
        check("R7 vblank raises lines 1 and 2", {29'd0, cpu_irq}, 32'd6);
        bus_write(3'd6, 32'h1);
        bus_read(3'd0, v);
        check("R7 setting ctrl bit keeps status", v, 32'h80);
        bus_write(3'd6, 32'h0);
        check("R7 1-to-0 write drops lines", {29'd0, cpu_irq}, 32'd0);
        bus_read(3'd0, v);
        check("R7 1-to-0 write clears vblank status", v, 32'h0);
        @(negedge clk);
        src_req = 8'h00;
        @(negedge clk);
        src_req = 8'h80;
        @(negedge clk);
        bus_write(3'd6, 32'h0);
        bus_read(3'd0, v);
        check("R7 0-to-0 write has no effect", v, 32'h80);
        check("R7 0-to-0 write keeps line 1", {31'd0, cpu_irq[1]}, 32'd1);
        bus_write(3'd6, 32'h1);
        @(negedge clk);
        src_req = 8'h00;
        @(negedge clk);
        src_req = 8'h80;
        bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(3'd0, v);
        check("R7 rise wins over clear", v, 32'h80);

        // R4 R10: read-only registers, widths, spare address
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_read(3'd2, v);
        check("R4 cause write ignored", v, 32'h80);
        bus_write(3'd0, 32'h0000_00FF);
        bus_read(3'd0, v);
        check("R10 status write ignored", v, 32'h80);
        bus_write(3'd3, 32'hFFFF_FF5A);
        bus_read(3'd3, v);
        check("R10 map upper bits read zero", v, 32'h5A);
        bus_write(3'd7, 32'hFFFF_FFFF);
        bus_read(3'd7, v);
        check("R10 spare address reads zero", v, 32'h0);
        bus_write(3'd6, 32'hFFFF_FFFF);
        bus_read(3'd6, v);
        check("R10 ctrl keeps bit 0 only", v, 32'h1);
        bus_read(3'd1, v);
        check("R10 enable readback", v, 32'hFF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule